// File: doc/BRIEF.md
# IDE I/O Window and Boot ROM Address Decoder

This block holds three I/O base address registers for an IDE function in a PCI configuration space. It also holds one mode register, and it decodes the PCI address of the current cycle into per-window hit flags. One mode bit selects narrow (16-bit) or wide (32-bit) I/O decode. In narrow mode the upper half of every I/O base register is held at zero: it reads back as zero and writes to it are dropped. Only address bits 15 and below are compared. In wide mode the upper half can be read and written, and all 32 bits are compared. A second mode bit sets the size of the boot ROM window at the top of the 4 GB memory space to 512 KB or 1 MB.

Software sizes and places the windows through a plain configuration port: a one-cycle write strobe, a dword index and a combinational read path. The decode side is combinational. The current address and command go in, and the hit flags come out in the same cycle. Bus protocol, claiming and data transfer are left to the surrounding logic. No interface carries a data stream, so there is no valid/ready handshake and no back-pressure: a write is taken on every cycle in which its strobe is high.

Top module: `ide_io_rom_decode`

## Requirements
- R1: After reset the mode register reads 00000000h, and each I/O base register reads 00000001h.
- R2: Bit 0 of each I/O base register always reads 1, to mark I/O space. The bits below its window size always read 0: bits 2:0 at byte offset 10h (8-byte window), bits 1:0 at offset 14h (4-byte window) and bits 3:0 at offset 20h (16-byte window).
- R3: While the wide bit is 0, bits 31:16 of every I/O base register read 0000h, and a write leaves the stored bits 31:16 unchanged.
- R4: While the wide bit is 0, a window hits when address bits 15 down to its size match the register, whatever address bits 31:16 hold.
- R5: While the wide bit is 1, bits 31:16 of each I/O base register are writable and readable, and all address bits from 31 down to the window size must match for a hit.
- R6: The I/O hit flag of a window, bit i of `io_hit` for the register at offset 10h, 14h or 20h (i = 0, 1, 2), can be 1 only for I/O Read (command 0010b) or I/O Write (0011b).
- R7: While the ROM-size bit is 0, `rom_hit` is 1 for addresses FFF80000h to FFFFFFFFh, and only for Memory Read (0110b), Memory Read Multiple (1100b) or Memory Read Line (1110b).
- R8: While the ROM-size bit is 1, the ROM window covers FFF00000h to FFFFFFFFh, under the same command rule as R7.
- R9: The mode register sits at byte offset 40h, with bit 0 = wide I/O decode and bit 1 = 1 MB ROM window. Its other bits read 0. Every offset that is not mapped reads 00000000h and ignores writes.
- R10: The hit flags and read data follow their inputs within the same cycle. A configuration write takes effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe, one word per cycle |
| cfg_addr | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for the register at `cfg_addr` |
| bus_addr | input | 32 | Address of the current bus cycle |
| bus_cmd | input | 4 | Command code of the current bus cycle |
| io_hit | output | 3 | One hit flag per I/O window |
| rom_hit | output | 1 | Boot ROM window hit |

## Verification
A corrupted base register or mode bit shows up at once, and in two places: in the combinational read data for that offset, and in the hit flags of the next cycle that probes the affected window. A write that slips through in narrow mode stays hidden until the wide bit is set. From that cycle it shows as nonzero upper read data and as lost hits at the expected addresses. For that reason the bench reads the registers back both before and after a mode change. It drives addresses just inside and just outside each window edge, so that a wrong compare width or a wrong ROM boundary is caught by a single vector.

// File: rtl/ioromdec_pkg.sv
package ioromdec_pkg;
  localparam int CFG_AW  = 6;
  localparam int NUM_BAR = 3;
  localparam int BUS_AW  = 32;

  localparam logic [CFG_AW-1:0] MODE_SLOT = 6'h10; // byte offset 40h

  localparam logic [3:0] CMD_IO_RD   = 4'b0010;
  localparam logic [3:0] CMD_IO_WR   = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [3:0] CMD_MEM_RDM = 4'b1100;
  localparam logic [3:0] CMD_MEM_RDL = 4'b1110;

  // dword index of each I/O window register
  function automatic logic [CFG_AW-1:0] bar_slot(input int idx);
    case (idx)
      0:       return 6'h04;
      1:       return 6'h05;
      default: return 6'h08;
    endcase
  endfunction

  // log2 of the window size in bytes
  function automatic int bar_size_log2(input int idx);
    case (idx)
      0:       return 3;
      1:       return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic cmd_is_io(input logic [3:0] cmd);
    return (cmd == CMD_IO_RD) || (cmd == CMD_IO_WR);
  endfunction

  function automatic logic cmd_is_mem_rd(input logic [3:0] cmd);
    return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_RDM) || (cmd == CMD_MEM_RDL);
  endfunction
endpackage

// File: rtl/ioromdec_mode.sv
module ioromdec_mode
  import ioromdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CFG_AW-1:0] waddr,
  input  logic [1:0]        wdata,
  output logic              wide,
  output logic              big_rom
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide    <= 1'b0;
      big_rom <= 1'b0;
    end else if (wr && waddr == MODE_SLOT) begin
      wide    <= wdata[0];
      big_rom <= wdata[1];
    end
  end
endmodule

// File: rtl/ioromdec_bar.sv
module ioromdec_bar
  import ioromdec_pkg::*;
#(
  parameter int                SIZE_LOG2 = 3,
  parameter logic [CFG_AW-1:0] SLOT      = 6'h04,
  parameter int                AW        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              wr,
  input  logic [CFG_AW-1:0] waddr,
  input  logic [AW-1:0]     wdata,
  output logic [AW-1:0]     rd_value,
  input  logic [AW-1:0]     bus_addr,
  input  logic              is_io,
  output logic              hit
);
  localparam int          HALF     = AW / 2;
  localparam logic [AW-1:0] LOW_MASK = (AW'(1) << SIZE_LOG2) - AW'(1);
  localparam logic [AW-1:0] LOW_HALF = {{(AW-HALF){1'b0}}, {HALF{1'b1}}};

  logic [AW-1:0] base_q;
  logic [AW-1:0] live_mask;

  // bits that are stored, read back and compared in the current mode
  assign live_mask = wide ? ~LOW_MASK : (~LOW_MASK & LOW_HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      base_q <= '0;
    else if (wr && waddr == SLOT)
      base_q <= (base_q & ~live_mask) | (wdata & live_mask);
  end

  assign rd_value = (base_q & live_mask) | AW'(1);
  assign hit      = is_io && ((bus_addr & live_mask) == (base_q & live_mask));
endmodule

// File: rtl/ioromdec_rom.sv
module ioromdec_rom #(
  parameter int AW         = 32,
  parameter int SMALL_LOG2 = 19,
  parameter int BIG_LOG2   = 20
) (
  input  logic          big_rom,
  input  logic          is_mem_rd,
  input  logic [AW-1:0] bus_addr,
  output logic          hit
);
  logic top_small, top_big;
  assign top_small = &bus_addr[AW-1:SMALL_LOG2];
  assign top_big   = &bus_addr[AW-1:BIG_LOG2];
  assign hit       = is_mem_rd && (big_rom ? top_big : top_small);
endmodule

// File: rtl/ide_io_rom_decode.sv
module ide_io_rom_decode
  import ioromdec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [3:0]         bus_cmd,
  output logic [NUM_BAR-1:0] io_hit,
  output logic               rom_hit
);
  logic        wide, big_rom;
  logic        is_io, is_mem_rd;
  logic [31:0] bar_rd [NUM_BAR];

  assign is_io     = cmd_is_io(bus_cmd);
  assign is_mem_rd = cmd_is_mem_rd(bus_cmd);

  ioromdec_mode u_mode (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .waddr(cfg_addr),
    .wdata(cfg_wdata[1:0]), .wide(wide), .big_rom(big_rom)
  );

  for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
    ioromdec_bar #(
      .SIZE_LOG2(bar_size_log2(i)), .SLOT(bar_slot(i)), .AW(BUS_AW)
    ) u_bar (
      .clk(clk), .rst_n(rst_n), .wide(wide), .wr(cfg_wr), .waddr(cfg_addr),
      .wdata(cfg_wdata), .rd_value(bar_rd[i]), .bus_addr(bus_addr),
      .is_io(is_io), .hit(io_hit[i])
    );
  end

  ioromdec_rom #(.AW(BUS_AW)) u_rom (
    .big_rom(big_rom), .is_mem_rd(is_mem_rd), .bus_addr(bus_addr), .hit(rom_hit)
  );

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == MODE_SLOT)
      cfg_rdata = {30'd0, big_rom, wide};
    for (int i = 0; i < NUM_BAR; i++)
      if (cfg_addr == bar_slot(i))
        cfg_rdata = bar_rd[i];
  end
endmodule

// File: rtl/ide_io_rom_decode_chk.sv
module ide_io_rom_decode_chk
  import ioromdec_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr,
  input logic [CFG_AW-1:0]  cfg_addr,
  input logic [31:0]        cfg_wdata,
  input logic [31:0]        cfg_rdata,
  input logic [BUS_AW-1:0]  bus_addr,
  input logic [3:0]         bus_cmd,
  input logic [NUM_BAR-1:0] io_hit,
  input logic               rom_hit,
  input logic               wide,
  input logic               big_rom
);
  logic at_bar;
  assign at_bar = (cfg_addr == bar_slot(0)) || (cfg_addr == bar_slot(1)) ||
                  (cfg_addr == bar_slot(2));

  assert_bar_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    at_bar |-> cfg_rdata[0]);

  assert_narrow_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_bar && !wide) |-> cfg_rdata[31:16] == 16'h0000);

  assert_io_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|io_hit) |-> cmd_is_io(bus_cmd));

  assert_rom_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rom_hit |-> cmd_is_mem_rd(bus_cmd));

  assert_rom_small_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_hit && !big_rom) |-> bus_addr[31:19] == 13'h1FFF);

  assert_rom_big_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rom_hit |-> bus_addr[31:20] == 12'hFFF);

  assert_mode_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == MODE_SLOT) |=> (wide == $past(cfg_wdata[0])) &&
                                          (big_rom == $past(cfg_wdata[1])));

  assert_mode_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == MODE_SLOT) |-> cfg_rdata[31:2] == 30'd0);
endmodule

bind ide_io_rom_decode ide_io_rom_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_addr(bus_addr),
  .bus_cmd(bus_cmd), .io_hit(io_hit), .rom_hit(rom_hit),
  .wide(wide), .big_rom(big_rom)
);

// File: tb/sim_ide_io_rom_decode.sv
module sim_ide_io_rom_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] bus_addr = '0;
  logic [3:0]  bus_cmd = 4'h0;
  logic [2:0]  io_hit;
  logic        rom_hit;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  ide_io_rom_decode u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_addr(bus_addr),
    .bus_cmd(bus_cmd), .io_hit(io_hit), .rom_hit(rom_hit)
  );

  // {mode[1:0], cmd[3:0], addr[31:0], exp_io[2:0], exp_rom}
  localparam int NV = 16;
  localparam logic [41:0] VEC [NV] = '{
    {2'b00, 4'h2, 32'h000001F3, 3'b001, 1'b0},
    {2'b00, 4'h2, 32'h000001F8, 3'b000, 1'b0},
    {2'b00, 4'h3, 32'hABCD01F5, 3'b001, 1'b0},
    {2'b00, 4'h2, 32'h000003F5, 3'b010, 1'b0},
    {2'b00, 4'h3, 32'h0000FFAF, 3'b100, 1'b0},
    {2'b00, 4'h6, 32'h000001F3, 3'b000, 1'b0},
    {2'b00, 4'h6, 32'hFFF80000, 3'b000, 1'b1},
    {2'b00, 4'h6, 32'hFFF7FFFC, 3'b000, 1'b0},
    {2'b00, 4'hC, 32'hFFFFFFFF, 3'b000, 1'b1},
    {2'b00, 4'h7, 32'hFFF80000, 3'b000, 1'b0},
    {2'b00, 4'hE, 32'hFFF80000, 3'b000, 1'b1},
    {2'b01, 4'h3, 32'hABCD01F5, 3'b000, 1'b0},
    {2'b01, 4'h2, 32'h000001F5, 3'b001, 1'b0},
    {2'b10, 4'h6, 32'hFFF00000, 3'b000, 1'b1},
    {2'b10, 4'h6, 32'hFFEFFFFC, 3'b000, 1'b0},
    {2'b00, 4'h6, 32'hFFF00000, 3'b000, 1'b0}
  };

  task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic check_read(input logic [5:0] a, input logic [31:0] exp, input string req);
    cfg_addr = a;
    #2;
    total++;
    if (cfg_rdata !== exp) begin
      bad++;
      $display("FAIL %s read idx %0h: got %h expected %h", req, a, cfg_rdata, exp);
    end
  endtask

  task automatic check_bus(input logic [3:0] cmd, input logic [31:0] addr,
                           input logic [2:0] eio, input logic erom, input string req);
    bus_cmd = cmd; bus_addr = addr;
    #2;
    total++;
    if (io_hit !== eio || rom_hit !== erom) begin
      bad++;
      $display("FAIL %s cmd %h addr %h: got io=%b rom=%b expected io=%b rom=%b",
               req, cmd, addr, io_hit, rom_hit, eio, erom);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    check_read(6'h10, 32'h00000000, "R1");
    check_read(6'h04, 32'h00000001, "R1");
    check_read(6'h05, 32'h00000001, "R1");
    check_read(6'h08, 32'h00000001, "R1");

    // program windows in narrow mode; upper write must be dropped (R3)
    cfg_write(6'h04, 32'hFFFF01FF);
    check_read(6'h04, 32'h000001F9, "R2");
    cfg_write(6'h04, 32'hFFFF01F0);
    check_read(6'h04, 32'h000001F1, "R3");
    cfg_write(6'h05, 32'h000003F6);
    check_read(6'h05, 32'h000003F5, "R2");
    cfg_write(6'h08, 32'h0000FFAF);
    check_read(6'h08, 32'h0000FFA1, "R2");

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      string req;
      v = VEC[i];
      cfg_write(6'h10, {30'd0, v[41:40]});
      if (v[0] || v[39:36] == 4'h6 || v[39:36] == 4'hC ||
          v[39:36] == 4'hE || v[39:36] == 4'h7)
        req = v[41] ? "R8" : "R7";
      else if (v[40])
        req = "R5";
      else
        req = (v[39:36] == 4'h2 || v[39:36] == 4'h3) ? "R4" : "R6";
      @(negedge clk);
      check_bus(v[39:36], v[35:4], v[3:1], v[0], req);
    end

    // R6: matching address but non-I/O command
    check_bus(4'h7, 32'h000001F3, 3'b000, 1'b0, "R6");

    // R3: the write dropped in narrow mode stays dropped once wide
    cfg_write(6'h10, 32'h00000001);
    check_read(6'h04, 32'h000001F1, "R3");
    // R5 wide writes and full compare
    cfg_write(6'h04, 32'h123401F0);
    check_read(6'h04, 32'h123401F1, "R5");
    check_bus(4'h2, 32'h123401F2, 3'b001, 1'b0, "R5");
    check_bus(4'h2, 32'h000001F2, 3'b000, 1'b0, "R5");
    // back to narrow: upper reads zero, compare ignores it
    cfg_write(6'h10, 32'h00000000);
    check_read(6'h04, 32'h000001F1, "R3");
    check_bus(4'h3, 32'h000001F2, 3'b001, 1'b0, "R4");

    // R9 mode register bits and unmapped offsets
    cfg_write(6'h10, 32'hFFFFFFFF);
    check_read(6'h10, 32'h00000003, "R9");
    cfg_write(6'h06, 32'hDEADBEEF);
    check_read(6'h06, 32'h00000000, "R9");
    check_read(6'h04, 32'h123401F1, "R9");

    // R10: write visible right after the edge
    @(negedge clk);
    cfg_addr = 6'h10; cfg_wdata = 32'h0; cfg_wr = 1'b1;
    bus_cmd = 4'h6; bus_addr = 32'hFFF40000;
    #2;
    total++;
    if (rom_hit !== 1'b1) begin
      bad++;
      $display("FAIL R10 before edge: got rom=%b expected rom=1", rom_hit);
    end
    @(negedge clk);
    cfg_wr = 1'b0;
    #2;
    total++;
    if (rom_hit !== 1'b0) begin
      bad++;
      $display("FAIL R10 after edge: got rom=%b expected rom=0", rom_hit);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule